// File: doc/BRIEF.md
# Brown-out Reset Sequencer with Power-up Delay

This block turns a supply-low flag from an analog comparator into a clean device reset for a microcontroller. It filters short supply dips with a cycle counter, holds reset for as long as the supply stays low, and can add an optional power-up delay after the supply recovers. A two-bit enable mode chooses whether detection is always off, gated by a software bit, active only outside sleep, or always on. A two-bit threshold code from the configuration passes straight through to the comparator.

Two status bits record what caused the last reset. A power-on pulse clears both bits. A brown-out trip clears only the brown-out bit. Software sets the bits back to 1 through a small write port. If the brown-out bit reads 0 while the power-on bit reads 1, a brown-out has occurred since software last set the bits. The filter length and the power-up delay are parameters counted in clock cycles.

Top module: `bor_sequencer`

## Requirements
- R1: The enable mode `cfg_mode` decodes as follows. 2'b00 means detection is off. 2'b01 means detection follows the software enable bit. 2'b10 means detection is on except while `sleep_active` is high. 2'b11 means detection is always on.
- R2: `swen_rd` shows the software enable bit only when `cfg_mode` is 2'b01 and reads 0 in every other mode. A write (`reg_wr` high, bit 0 of `reg_wdata`) changes the bit only in mode 2'b01. Writes in other modes are ignored.
- R3: With mode 2'b01 and the software enable bit cleared, a supply dip of any length never asserts `dev_reset`.
- R4: With detection on, `supply_low` sampled high on FILT_CYC consecutive clock edges does not assert reset. On the next consecutive low edge, `dev_reset` rises right after that edge.
- R5: Once tripped, `dev_reset` stays high for as long as `supply_low` stays high.
- R6: When `supply_low` falls during a brown-out, the release depends on `pwrt_en`. With `pwrt_en` = 0, `dev_reset` falls after the next edge. With `pwrt_en` = 1, `dev_reset` stays high for PWRT_CYC further cycles and falls after edge PWRT_CYC+1.
- R7: A low supply seen with detection on while the power-up delay runs returns the block to brown-out hold. After the next recovery, the full PWRT_CYC delay starts again from zero.
- R8: Status bit positions are `bor_flag` at `reg_wdata[2]` and `por_flag` at `reg_wdata[1]`, both loaded on a write. A brown-out trip clears `bor_flag` and leaves `por_flag` alone. A power-on pulse clears both, and a hardware clear wins over a write.
- R9: `cmp_level` always equals `cfg_level`, and register writes never change it.
- R10: A `por_pulse` forces reset, sets the software enable bit to 1 and clears both counters. After the pulse ends, the block releases as in R6. An asynchronous reset leaves both status bits at 0 and the software enable bit at 1.
- R11: In mode 2'b10, leaving sleep turns detection back on with no software action. The filter count restarts from zero, so a dip that began during sleep needs FILT_CYC+1 low edges after wake-up to trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_low | input | 1 | Comparator flag: supply below threshold |
| por_pulse | input | 1 | Power-on reset pulse |
| cfg_mode | input | 2 | Detection enable mode |
| cfg_level | input | 2 | Threshold select configuration |
| pwrt_en | input | 1 | Power-up delay enable |
| sleep_active | input | 1 | Device is in sleep |
| reg_wr | input | 1 | Status/control register write strobe |
| reg_wdata | input | 3 | Write data: [0] software enable, [1] power-on bit, [2] brown-out bit |
| dev_reset | output | 1 | Device reset, active high |
| cmp_level | output | 2 | Threshold select to the comparator |
| swen_rd | output | 1 | Software enable readback |
| por_flag | output | 1 | Power-on status bit |
| bor_flag | output | 1 | Brown-out status bit |

## Verification
The bench aims at the filter boundary. A dip of exactly FILT_CYC low edges must pass, and one more edge must trip. An off-by-one counter would either reset on a legal glitch or let a real brown-out slip through for an extra cycle. It counts the power-up delay to the exact cycle, and it cuts the delay with a second dip. A timer that resumes instead of restarting would release reset too early. It also wakes from sleep partway through a dip, where a filter count kept across sleep would trip too soon. Further tests write the software bit in locked modes and check that the threshold select ignores writes. Either fault shows up as a changed readback.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_SW      = 2'b01,
    MODE_NOSLEEP = 2'b10,
    MODE_ON      = 2'b11
  } det_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_HOLD  = 2'b01,
    ST_TIMER = 2'b10,
    ST_POR   = 2'b11
  } seq_state_e;

  localparam int unsigned WDATA_SWEN = 0;
  localparam int unsigned WDATA_POR  = 1;
  localparam int unsigned WDATA_BOR  = 2;
  localparam int unsigned WDATA_W    = 3;
endpackage

// File: rtl/bor_rst_sync.sv
module bor_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bor_enable_ctl.sv
module bor_enable_ctl
  import bor_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_pulse,
  input  logic [1:0] cfg_mode,
  input  logic       sleep_active,
  input  logic       wr_en,
  input  logic       wr_swen,
  output logic       det_en,
  output logic       swen_rd
);
  det_mode_e mode;
  logic      swen_q, swen_d, swen_ce;

  assign mode = det_mode_e'(cfg_mode);

  always_comb begin
    swen_ce = 1'b0;
    swen_d  = swen_q;
    if (por_pulse) begin
      swen_ce = 1'b1;
      swen_d  = 1'b1;
    end else if (wr_en && mode == MODE_SW) begin
      swen_ce = 1'b1;
      swen_d  = wr_swen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       swen_q <= 1'b1;
    else if (swen_ce) swen_q <= swen_d;
  end

  always_comb begin
    unique case (mode)
      MODE_OFF:     det_en = 1'b0;
      MODE_SW:      det_en = swen_q;
      MODE_NOSLEEP: det_en = !sleep_active;
      default:      det_en = 1'b1;
    endcase
  end

  assign swen_rd = (mode == MODE_SW) && swen_q;

  p_swen_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_pulse && !(wr_en && cfg_mode == 2'b01)) |=> $stable(swen_q));

  p_por_sets_swen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> swen_q);
endmodule

// File: rtl/bor_dip_filter.sv
module bor_dip_filter #(
  parameter int unsigned FILT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic arm,
  input  logic supply_low,
  output logic trip
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = 1'b1;
    cnt_d  = cnt_q;
    if (clear || !arm || !supply_low) cnt_d = '0;
    else if (cnt_q != LIMIT)          cnt_d = cnt_q + 1'b1;
    else                              cnt_ce = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign trip = arm && supply_low && !clear && (cnt_q == LIMIT);

  p_filter_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm || clear) |=> (cnt_q == '0));

  p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/bor_seq_fsm.sv
module bor_seq_fsm
  import bor_pkg::*;
#(
  parameter int unsigned PWRT_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_pulse,
  input  logic supply_low,
  input  logic det_en,
  input  logic pwrt_en,
  input  logic trip,
  output logic in_run,
  output logic dev_reset
);
  localparam int unsigned TW = $clog2(PWRT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(PWRT_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          low_seen;

  assign low_seen = supply_low && det_en;

  always_comb begin
    state_d = state_q;
    if (por_pulse) begin
      state_d = ST_POR;
    end else begin
      unique case (state_q)
        ST_RUN:   if (trip) state_d = ST_HOLD;
        ST_HOLD:  if (!supply_low) state_d = pwrt_en ? ST_TIMER : ST_RUN;
        ST_TIMER: begin
          if (low_seen)            state_d = ST_HOLD;
          else if (tcnt_q == LAST) state_d = ST_RUN;
        end
        default: begin
          if (low_seen) state_d = ST_HOLD;
          else          state_d = pwrt_en ? ST_TIMER : ST_RUN;
        end
      endcase
    end
  end

  always_comb begin
    if (state_q == ST_TIMER && state_d == ST_TIMER) tcnt_d = tcnt_q + 1'b1;
    else                                            tcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
    end
  end

  assign in_run    = (state_q == ST_RUN);
  assign dev_reset = !in_run;

  p_trip_needs_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_reset) && !$past(por_pulse)) |-> $past(supply_low));

  p_low_holds_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_reset && low_seen && !por_pulse) |=> dev_reset);

  p_timer_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TIMER && $past(state_q) != ST_TIMER) |-> (tcnt_q == '0));
endmodule

// File: rtl/bor_sequencer.sv
module bor_sequencer
  import bor_pkg::*;
#(
  parameter int unsigned FILT_CYC = 8,
  parameter int unsigned PWRT_CYC = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_low,
  input  logic       por_pulse,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_level,
  input  logic       pwrt_en,
  input  logic       sleep_active,
  input  logic       reg_wr,
  input  logic [2:0] reg_wdata,
  output logic       dev_reset,
  output logic [1:0] cmp_level,
  output logic       swen_rd,
  output logic       por_flag,
  output logic       bor_flag
);
  logic rst_ni, det_en, trip, in_run;
  logic por_q, por_d, bor_q, bor_d;

  bor_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  bor_enable_ctl u_en (
    .clk(clk), .rst_n(rst_ni), .por_pulse(por_pulse), .cfg_mode(cfg_mode),
    .sleep_active(sleep_active), .wr_en(reg_wr), .wr_swen(reg_wdata[WDATA_SWEN]),
    .det_en(det_en), .swen_rd(swen_rd)
  );

  bor_dip_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_ni), .clear(por_pulse), .arm(det_en && in_run),
    .supply_low(supply_low), .trip(trip)
  );

  bor_seq_fsm #(.PWRT_CYC(PWRT_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_ni), .por_pulse(por_pulse), .supply_low(supply_low),
    .det_en(det_en), .pwrt_en(pwrt_en), .trip(trip), .in_run(in_run),
    .dev_reset(dev_reset)
  );

  always_comb begin
    por_d = por_q;
    bor_d = bor_q;
    if (por_pulse) begin
      por_d = 1'b0;
      bor_d = 1'b0;
    end else begin
      if (reg_wr) begin
        por_d = reg_wdata[WDATA_POR];
        bor_d = reg_wdata[WDATA_BOR];
      end
      if (trip) bor_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q <= 1'b0;
      bor_q <= 1'b0;
    end else begin
      por_q <= por_d;
      bor_q <= bor_d;
    end
  end

  assign por_flag  = por_q;
  assign bor_flag  = bor_q;
  assign cmp_level = cfg_level;

  p_por_clears_flags_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    por_pulse |=> (!por_flag && !bor_flag));

  p_trip_clears_bor_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    trip |=> (!bor_flag && dev_reset));

  p_por_forces_reset_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    por_pulse |=> dev_reset);
endmodule

// File: tb/bor_sequencer_test.sv
module bor_sequencer_test;
  localparam int F = 8;
  localparam int P = 32;

  logic clk = 1'b0;
  logic rst_n, supply_low, por_pulse, pwrt_en, sleep_active, reg_wr;
  logic [1:0] cfg_mode, cfg_level;
  logic [2:0] reg_wdata;
  logic dev_reset, swen_rd, por_flag, bor_flag;
  logic [1:0] cmp_level;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bor_sequencer #(.FILT_CYC(F), .PWRT_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .por_pulse(por_pulse),
    .cfg_mode(cfg_mode), .cfg_level(cfg_level), .pwrt_en(pwrt_en),
    .sleep_active(sleep_active), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .dev_reset(dev_reset), .cmp_level(cmp_level), .swen_rd(swen_rd),
    .por_flag(por_flag), .bor_flag(bor_flag)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic recover(input int n);
    supply_low = 1'b0;
    step(n);
  endtask

  task automatic t_reset;
    cfg_mode = 2'b01; cfg_level = 2'b00; pwrt_en = 1'b0; sleep_active = 1'b0;
    supply_low = 1'b0; por_pulse = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rst_n = 1'b0;
    step(3);
    chk(dev_reset, 1, "R10 reset held during rst_n");
    rst_n = 1'b1;
    step(5);
    chk(dev_reset, 0, "R10 released after rst_n");
    chk(swen_rd, 1, "R10 swen set at reset");
    chk({por_flag, bor_flag}, 2'b00, "R10 flags zero at reset");
  endtask

  task automatic t_filter;
    cfg_mode = 2'b11;
    supply_low = 1'b1; step(F);
    chk(dev_reset, 0, "R4 dip of FILT_CYC edges ignored");
    recover(3);
    chk(dev_reset, 0, "R4 still running after short dip");
    supply_low = 1'b1; step(F + 1);
    chk(dev_reset, 1, "R4 dip of FILT_CYC+1 trips");
    step(25);
    chk(dev_reset, 1, "R5 reset held while supply low");
    recover(1);
    chk(dev_reset, 0, "R6 release next edge without timer");
  endtask

  task automatic t_pwrt;
    cfg_mode = 2'b11; pwrt_en = 1'b1;
    supply_low = 1'b1; step(F + 1);
    chk(dev_reset, 1, "R6 tripped");
    recover(P);
    chk(dev_reset, 1, "R6 held through timer");
    step(1);
    chk(dev_reset, 0, "R6 released after PWRT_CYC+1 edges");
  endtask

  task automatic t_restart;
    cfg_mode = 2'b11; pwrt_en = 1'b1;
    supply_low = 1'b1; step(F + 1);
    recover(11);
    supply_low = 1'b1; step(3);
    chk(dev_reset, 1, "R7 dip during timer holds reset");
    recover(P);
    chk(dev_reset, 1, "R7 timer restarted from zero");
    step(1);
    chk(dev_reset, 0, "R7 release after full delay");
    pwrt_en = 1'b0;
  endtask

  task automatic t_modes;
    cfg_mode = 2'b00;
    supply_low = 1'b1; step(F + 6);
    chk(dev_reset, 0, "R1 mode 00 detection off");
    recover(2);
    cfg_mode = 2'b11; sleep_active = 1'b1;
    supply_low = 1'b1; step(F + 1);
    chk(dev_reset, 1, "R1 mode 11 active in sleep");
    recover(2);
    cfg_mode = 2'b10;
    supply_low = 1'b1; step(F + 6);
    chk(dev_reset, 0, "R1 mode 10 off during sleep");
    sleep_active = 1'b0; step(F);
    chk(dev_reset, 0, "R11 count restarts on wake");
    step(1);
    chk(dev_reset, 1, "R11 trips FILT_CYC+1 after wake");
    recover(2);
  endtask

  task automatic t_swen;
    cfg_mode = 2'b01;
    wr(3'b000);
    chk(swen_rd, 0, "R2 swen written 0 in mode 01");
    supply_low = 1'b1; step(F + 6);
    chk(dev_reset, 0, "R3 swen cleared disables detection");
    recover(2);
    cfg_mode = 2'b10; wr(3'b001);
    chk(swen_rd, 0, "R2 reads 0 outside mode 01");
    cfg_mode = 2'b01; step(1);
    chk(swen_rd, 0, "R2 write outside mode 01 ignored");
    wr(3'b001);
    chk(swen_rd, 1, "R2 swen written 1 in mode 01");
    supply_low = 1'b1; step(F + 1);
    chk(dev_reset, 1, "R1 mode 01 follows swen");
    recover(2);
  endtask

  task automatic t_flags;
    cfg_mode = 2'b01; pwrt_en = 1'b0;
    wr(3'b111);
    chk({bor_flag, por_flag}, 2'b11, "R8 software sets flags");
    supply_low = 1'b1; step(F + 1);
    chk({bor_flag, por_flag}, 2'b01, "R8 brown-out clears bor only");
    recover(2);
    wr(3'b110);
    por_pulse = 1'b1; step(1);
    chk({bor_flag, por_flag}, 2'b00, "R8 por clears both flags");
    chk(dev_reset, 1, "R10 por forces reset");
    chk(swen_rd, 1, "R10 por sets swen");
    por_pulse = 1'b0; step(1);
    chk(dev_reset, 0, "R10 release after por without timer");
    pwrt_en = 1'b1;
    por_pulse = 1'b1; step(1);
    por_pulse = 1'b0; step(P);
    chk(dev_reset, 1, "R10 timer runs after por");
    step(1);
    chk(dev_reset, 0, "R10 release after por timer");
    pwrt_en = 1'b0;
  endtask

  task automatic t_level;
    cfg_mode = 2'b01; cfg_level = 2'b10;
    wr(3'b111);
    chk(cmp_level, 2'b10, "R9 level from config");
    cfg_level = 2'b01; wr(3'b000);
    chk(cmp_level, 2'b01, "R9 level unchanged by write");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_filter();
    t_pwrt();
    t_restart();
    t_modes();
    t_swen();
    t_flags();
    t_level();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule